// File: doc/BRIEF.md
# Dual-Channel High/Low PWM Generator

The block produces two independent pulse-width-modulated outputs. Each waveform is set by two phase lengths rather than a period and a compare value: the output stays high for a programmed number of prescaled ticks and then low for a second programmed number, and this repeats. Each channel picks one of four tick strobes that arrive in the system clock domain. It divides that strobe by a 7-bit prescaler and counts the divided ticks only while both its clock gate and its output enable are set.

Software programs the block through a small memory-mapped bus with a valid/ready handshake. Each channel has one duty word that packs both lengths, and a single shared control word holds the enables, gates, source selectors and prescaler values for both channels. There is no polarity control. An inverted waveform is obtained by exchanging the two lengths. Clearing a channel's enable forces its output low without finishing the running period. New lengths take effect only when a new high phase begins.

Top module: `pwm_dual_hilo`

## Requirements
- R1: After reset every register reads 0, `pwm_out` is 0 and `rsp_valid` is 0.
- R2: The duty words at byte addresses 0x0 (channel 0) and 0x4 (channel 1) read back all 32 bits as written. The control word at 0x8 reads back only its defined bits (mask 0x00FFFFF3). Any other address reads 0 and ignores writes.
- R3: A channel runs only when its enable bit (control bit 0 for channel 0, bit 1 for channel 1) and its gate bit (bit 15 for channel 0, bit 23 for channel 1) are both 1. Otherwise its output is 0.
- R4: Duty bits 31:16 give the high length H and bits 15:0 give the low length L. Once running, the output rises on the clock edge after the channel starts, holds high for H prescaled ticks, then low for L ticks, and repeats.
- R5: The source selector (control bits 5:4 for channel 0, 7:6 for channel 1) picks `src_tick[sel]`. The prescaler field d (bits 14:8 for channel 0, 22:16 for channel 1) emits one tick every d+1 selected strobes.
- R6: With H = 0 the output stays low. With L = 0 and H > 0 it stays high without a gap.
- R7: With H = 0 and L = 0 the output stays low.
- R8: When a write clears a channel's enable bit, that channel's output is 0 from the second clock edge after the write is accepted, whatever phase it was in.
- R9: A duty write is taken into use only at the start of the next high phase. The running high and low phases keep their old lengths.
- R10: The two channels are independent. Each keeps its own timing while the other runs with different settings.
- R11: `req_ready` is always 1. A read returns its data with `rsp_valid` = 1 on the clock edge after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Four tick-strobe sources, one cycle wide each |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pwm_out | output | 2 | Registered PWM outputs, one bit per channel |

## Verification
Each channel is driven with strobes that fire every cycle, every second, third and fifth cycle. Each source is combined with several prescaler values, so a wrong source choice, a wrong divisor or an off-by-one in the tick counter changes the measured high and low lengths. Lengths of zero on either side, and on both, test the constant-level paths apart from normal toggling. A duty write during a high phase shows whether lengths are reloaded early or only at the period boundary. A disable issued during a high phase tells an immediate stop from one that waits for the period to end. A behavioural model runs next to the design, and both channels are compared with it on every cycle while they run different settings.

// File: rtl/pwm_hl_pkg.sv
package pwm_hl_pkg;
  localparam int NUM_CH  = 2;
  localparam int CNT_W   = 16;
  localparam int DIV_W   = 7;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 1 << SEL_W;
  localparam int REG_W   = 2 * CNT_W;
  localparam int ADDR_W  = 4;

  // control word layout: enables at the bottom, selectors above, then per-channel divider+gate bytes
  function automatic int sel_pos(input int ch);
    return 4 + SEL_W * ch;
  endfunction

  function automatic int div_pos(input int ch);
    return 8 + 8 * ch;
  endfunction

  function automatic int gate_pos(input int ch);
    return div_pos(ch) + DIV_W;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[c]                   = 1'b1;
      m[sel_pos(c) +: SEL_W] = '1;
      m[div_pos(c) +: DIV_W] = '1;
      m[gate_pos(c)]         = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] duty_ofs(input int ch);
    return ADDR_W'(4 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] ctrl_ofs();
    return ADDR_W'(4 * NUM_CH);
  endfunction

  // prescaler wraps when the strobe count reaches the divider field
  function automatic logic presc_hit(input logic [DIV_W-1:0] cnt, input logic [DIV_W-1:0] div);
    return cnt >= div;
  endfunction

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_HIGH = 2'd1, PH_LOW = 2'd2} phase_t;
endpackage

// File: rtl/pwm_hl_regs.sv
module pwm_hl_regs
  import pwm_hl_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_CH     = NUM_CH,
  parameter int P_CNT_W  = CNT_W,
  parameter int P_DIV_W  = DIV_W,
  parameter int P_SEL_W  = SEL_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [P_ADDR_W-1:0]             req_addr,
  input  logic [2*P_CNT_W-1:0]            req_wdata,
  output logic                            rsp_valid,
  output logic [2*P_CNT_W-1:0]            rsp_rdata,
  output logic [P_CH-1:0]                 run_o,
  output logic [P_CH-1:0][P_SEL_W-1:0]    sel_o,
  output logic [P_CH-1:0][P_DIV_W-1:0]    div_o,
  output logic [P_CH-1:0][P_CNT_W-1:0]    hi_o,
  output logic [P_CH-1:0][P_CNT_W-1:0]    lo_o
);
  localparam int W = 2 * P_CNT_W;
  localparam logic [W-1:0] CMASK = W'(ctrl_mask());
  localparam logic [P_ADDR_W-1:0] CTRL_A = P_ADDR_W'(ctrl_ofs());

  logic [W-1:0] duty_q [P_CH];
  logic [W-1:0] ctrl_q;
  logic [W-1:0] rdata_d;
  logic         wr_en, rd_en;

  assign wr_en = req_valid & req_write;
  assign rd_en = req_valid & ~req_write;

  for (genvar c = 0; c < P_CH; c++) begin : g_duty
    localparam logic [P_ADDR_W-1:0] DA = P_ADDR_W'(duty_ofs(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       duty_q[c] <= '0;
      else if (wr_en && req_addr == DA) duty_q[c] <= req_wdata;
    end
    assign hi_o[c]  = duty_q[c][W-1:P_CNT_W];
    assign lo_o[c]  = duty_q[c][P_CNT_W-1:0];
    assign run_o[c] = ctrl_q[c] & ctrl_q[gate_pos(c)];
    assign sel_o[c] = ctrl_q[sel_pos(c) +: P_SEL_W];
    assign div_o[c] = ctrl_q[div_pos(c) +: P_DIV_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ctrl_q <= '0;
    else if (wr_en && req_addr == CTRL_A) ctrl_q <= req_wdata & CMASK;
  end

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < P_CH; c++)
      if (req_addr == P_ADDR_W'(duty_ofs(c))) rdata_d = duty_q[c];
    if (req_addr == CTRL_A) rdata_d = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/pwm_hl_prescale.sv
module pwm_hl_prescale
  import pwm_hl_pkg::*;
#(
  parameter int P_DIV_W = DIV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               strobe,
  input  logic [P_DIV_W-1:0] div,
  output logic               tick
);
  logic [P_DIV_W-1:0] cnt_q;
  logic               wrap;

  assign wrap = presc_hit(cnt_q, div);
  assign tick = run & strobe & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (strobe) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_hl_phase.sv
module pwm_hl_phase
  import pwm_hl_pkg::*;
#(
  parameter int P_CNT_W = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [P_CNT_W-1:0] duty_hi,
  input  logic [P_CNT_W-1:0] duty_lo,
  output logic               pwm,
  output logic               started
);
  phase_t             st_q, st_d;
  logic [P_CNT_W-1:0] cnt_q, cnt_d, hi_q, hi_d, lo_q, lo_d;
  logic [P_CNT_W:0]   cnt_inc;
  logic               restart;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign started = (st_q != PH_IDLE);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    restart = 1'b0;
    if (!run) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        PH_IDLE: restart = 1'b1;
        PH_HIGH: if (tick) begin
          if (cnt_inc == {1'b0, hi_q}) begin
            if (lo_q != '0) begin
              st_d  = PH_LOW;
              cnt_d = '0;
            end else restart = 1'b1;
          end else cnt_d = cnt_inc[P_CNT_W-1:0];
        end
        PH_LOW: if (tick) begin
          if (cnt_inc >= {1'b0, lo_q}) restart = 1'b1;
          else                         cnt_d = cnt_inc[P_CNT_W-1:0];
        end
        default: st_d = PH_IDLE;
      endcase
      if (restart) begin
        hi_d  = duty_hi;
        lo_d  = duty_lo;
        cnt_d = '0;
        st_d  = (duty_hi != '0) ? PH_HIGH : PH_LOW;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      pwm   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      pwm   <= (st_d == PH_HIGH);
    end
  end
endmodule

// File: rtl/pwm_dual_hilo.sv
module pwm_dual_hilo
  import pwm_hl_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_CH     = NUM_CH,
  parameter int P_CNT_W  = CNT_W,
  parameter int P_DIV_W  = DIV_W,
  parameter int P_SEL_W  = SEL_W,
  localparam int P_SRC   = 1 << P_SEL_W,
  localparam int P_REG_W = 2 * P_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P_SRC-1:0]    src_tick,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [P_ADDR_W-1:0] req_addr,
  input  logic [P_REG_W-1:0]  req_wdata,
  output logic                rsp_valid,
  output logic [P_REG_W-1:0]  rsp_rdata,
  output logic [P_CH-1:0]     pwm_out
);
  logic [P_CH-1:0]              run_w, ptick_w, started_w, strobe_w;
  logic [P_CH-1:0][P_SEL_W-1:0] sel_w;
  logic [P_CH-1:0][P_DIV_W-1:0] div_w;
  logic [P_CH-1:0][P_CNT_W-1:0] hi_w, lo_w;

  assign req_ready = 1'b1;

  pwm_hl_regs #(
    .P_ADDR_W(P_ADDR_W), .P_CH(P_CH), .P_CNT_W(P_CNT_W),
    .P_DIV_W(P_DIV_W), .P_SEL_W(P_SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .run_o(run_w), .sel_o(sel_w), .div_o(div_w), .hi_o(hi_w), .lo_o(lo_w)
  );

  for (genvar c = 0; c < P_CH; c++) begin : g_ch
    assign strobe_w[c] = src_tick[sel_w[c]];

    pwm_hl_prescale #(.P_DIV_W(P_DIV_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run_w[c]), .strobe(strobe_w[c]),
      .div(div_w[c]), .tick(ptick_w[c])
    );

    pwm_hl_phase #(.P_CNT_W(P_CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run_w[c]), .tick(ptick_w[c]),
      .duty_hi(hi_w[c]), .duty_lo(lo_w[c]),
      .pwm(pwm_out[c]), .started(started_w[c])
    );
  end
endmodule

// File: rtl/pwm_hl_chk.sv
module pwm_hl_chk
  import pwm_hl_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_CH     = NUM_CH,
  parameter int P_DIV_W  = DIV_W,
  parameter int P_REG_W  = REG_W
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_write,
  input logic [P_ADDR_W-1:0]          req_addr,
  input logic [P_REG_W-1:0]           req_wdata,
  input logic                         rsp_valid,
  input logic [P_CH-1:0]              pwm_out,
  input logic [P_CH-1:0]              run_w,
  input logic [P_CH-1:0]              ptick_w,
  input logic [P_CH-1:0]              started_w,
  input logic [P_CH-1:0][P_DIV_W-1:0] div_w
);
  localparam logic [P_ADDR_W-1:0] CTRL_A = P_ADDR_W'(ctrl_ofs());

  // R11
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  for (genvar c = 0; c < P_CH; c++) begin : g_chk
    // R3
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_w[c] |=> !pwm_out[c]);

    // R4
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_w[c] && started_w[c] && !ptick_w[c]) |=> $stable(pwm_out[c]));

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptick_w[c] && div_w[c] != '0 && !(req_valid && req_write)) |=> !ptick_w[c]);

    // R8
    disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == CTRL_A && !req_wdata[c]) |=> ##1 !pwm_out[c]);
  end
endmodule

bind pwm_dual_hilo pwm_hl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .pwm_out(pwm_out), .run_w(run_w), .ptick_w(ptick_w),
  .started_w(started_w), .div_w(div_w)
);

// File: tb/tb_pwm_dual_hilo.sv
module tb_pwm_dual_hilo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = 4'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = 4'h0;
  logic [31:0] req_wdata = 32'h0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  pwm_out;

  int checks = 0, fails = 0, cyc = 0;
  bit compare_on = 1'b0;

  always #4 clk = ~clk;

  pwm_dual_hilo dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pwm_out(pwm_out)
  );

  // strobes: every cycle, every 2nd, every 3rd, every 5th
  always @(negedge clk) begin
    cyc++;
    src_tick = {(cyc % 5) == 0, (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_duty [2];
  logic [31:0] m_ctrl;
  int m_pre [2], m_left [2], m_hlen [2], m_llen [2], m_mode [2];  // mode 0 idle, 1 high, 2 low
  bit m_out [2];
  bit m_run, m_src, m_tk;
  int m_sel, m_div;

  task automatic m_begin(input int c);
    m_hlen[c] = int'(m_duty[c][31:16]);
    m_llen[c] = int'(m_duty[c][15:0]);
    if (m_hlen[c] > 0) begin m_mode[c] = 1; m_left[c] = m_hlen[c]; end
    else               begin m_mode[c] = 2; m_left[c] = (m_llen[c] > 0) ? m_llen[c] : 1; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int c = 0; c < 2; c++) begin
        m_duty[c] = 0; m_pre[c] = 0; m_mode[c] = 0; m_out[c] = 0; m_left[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        m_run = m_ctrl[c] && m_ctrl[15 + 8 * c];
        m_sel = int'((m_ctrl >> (4 + 2 * c)) & 32'h3);
        m_div = int'((m_ctrl >> (8 + 8 * c)) & 32'h7f);
        m_src = src_tick[m_sel];
        m_tk  = m_run && m_src && (m_pre[c] >= m_div);
        if (!m_run)     m_pre[c] = 0;
        else if (m_src) m_pre[c] = m_tk ? 0 : m_pre[c] + 1;
        if (!m_run) m_mode[c] = 0;
        else if (m_mode[c] == 0) m_begin(c);
        else if (m_tk) begin
          m_left[c]--;
          if (m_left[c] == 0) begin
            if (m_mode[c] == 1 && m_llen[c] > 0) begin m_mode[c] = 2; m_left[c] = m_llen[c]; end
            else m_begin(c);
          end
        end
        m_out[c] = (m_mode[c] == 1);
      end
      if (req_valid && req_write) begin
        if (req_addr == 4'h0) m_duty[0] = req_wdata;
        if (req_addr == 4'h4) m_duty[1] = req_wdata;
        if (req_addr == 4'h8) m_ctrl = req_wdata & 32'h00FF_FFF3;
      end
    end
  end

  // R4 R10: cycle-by-cycle comparison of both channels
  always @(negedge clk) begin
    if (rst_n && compare_on)
      for (int c = 0; c < 2; c++)
        chk(pwm_out[c] == m_out[c], $sformatf("R4/R10 model ch%0d cycle %0d", c, cyc),
            32'(pwm_out[c]), 32'(m_out[c]));
  end

  // ---------------- bus and measurement helpers ----------------
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    chk(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R11 rsp_valid", 32'(rsp_valid), 32'h1);
    chk(rsp_rdata == exp, tag, rsp_rdata, exp);
  endtask

  function automatic logic [31:0] mk_ctrl(input bit e0, input bit g0, input int s0, input int d0,
                                          input bit e1, input bit g1, input int s1, input int d1);
    return 32'(e0) | (32'(e1) << 1) | (32'(s0 & 3) << 4) | (32'(s1 & 3) << 6) |
           (32'(d0 & 127) << 8) | (32'(g0) << 15) | (32'(d1 & 127) << 16) | (32'(g1) << 23);
  endfunction

  task automatic wait_rise(input int c);
    logic last;
    last = pwm_out[c];
    forever begin
      @(negedge clk);
      if (pwm_out[c] && !last) break;
      last = pwm_out[c];
    end
  endtask

  task automatic run_len(input int c, input logic lvl, output int n);
    n = 0;
    while (pwm_out[c] == lvl) begin n++; @(negedge clk); end
  endtask

  task automatic measure(input int c, output int h, output int l);
    wait_rise(c);
    run_len(c, 1'b1, h);
    run_len(c, 1'b0, l);
  endtask

  task automatic count_high(input int c, input int n, output int highs);
    highs = 0;
    repeat (n) begin @(negedge clk); if (pwm_out[c]) highs++; end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    int h, l, n;
    repeat (3) @(negedge clk);
    // R1
    chk(pwm_out == 2'b00, "R1 pwm in reset", 32'(pwm_out), 32'h0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    compare_on = 1'b1;
    @(negedge clk);
    chk(pwm_out == 2'b00, "R1 pwm after reset", 32'(pwm_out), 32'h0);
    bus_read(4'h0, 32'h0, "R1 duty0 reset");
    bus_read(4'h4, 32'h0, "R1 duty1 reset");
    bus_read(4'h8, 32'h0, "R1 ctrl reset");

    // R2 read-back and masking
    bus_write(4'h0, 32'h1234_5678);
    bus_write(4'h4, 32'hFFFF_0001);
    bus_read(4'h0, 32'h1234_5678, "R2 duty0 readback");
    bus_read(4'h4, 32'hFFFF_0001, "R2 duty1 readback");
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, 32'h00FF_FFF3, "R2 ctrl masked readback");
    bus_write(4'h8, 32'h0);
    bus_write(4'hC, 32'hDEAD_BEEF);
    bus_read(4'hC, 32'h0, "R2 unmapped reads zero");
    bus_read(4'h0, 32'h1234_5678, "R2 unmapped write ignored");

    // R3: enable alone, then gate alone
    bus_write(4'h0, {16'd3, 16'd2});
    bus_write(4'h8, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0));
    count_high(0, 40, n);
    chk(n == 0, "R3 enable without gate", 32'(n), 32'h0);
    bus_write(4'h8, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0));
    count_high(0, 40, n);
    chk(n == 0, "R3 gate without enable", 32'(n), 32'h0);

    // R4: first rise on the edge after start
    bus_write(4'h8, mk_ctrl(1, 1, 0, 1, 0, 0, 0, 0));
    chk(pwm_out[0] == 1'b0, "R4 not yet high", 32'(pwm_out[0]), 32'h0);
    @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R4 rises after start", 32'(pwm_out[0]), 32'h1);
    // R4 R5: every strobe, divide by 2 -> 6 high, 4 low
    measure(0, h, l);
    measure(0, h, l);
    chk(h == 6, "R4 high length sel0 div1", 32'(h), 32'd6);
    chk(l == 4, "R4 low length sel0 div1", 32'(l), 32'd4);

    // R5: every 5th strobe, no divide, H2 L1 -> 10/5
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd2, 16'd1});
    bus_write(4'h8, mk_ctrl(1, 1, 3, 0, 0, 0, 0, 0));
    measure(0, h, l);
    measure(0, h, l);
    chk(h == 10, "R5 high length sel3 div0", 32'(h), 32'd10);
    chk(l == 5, "R5 low length sel3 div0", 32'(l), 32'd5);
    // R5: every 3rd strobe, divide by 3, H1 L1 -> 9/9
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd1, 16'd1});
    bus_write(4'h8, mk_ctrl(1, 1, 2, 2, 0, 0, 0, 0));
    measure(0, h, l);
    measure(0, h, l);
    chk(h == 9, "R5 high length sel2 div2", 32'(h), 32'd9);
    chk(l == 9, "R5 low length sel2 div2", 32'(l), 32'd9);

    // R6: zero high length stays low
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd0, 16'd5});
    bus_write(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    count_high(0, 60, n);
    chk(n == 0, "R6 zero high stays low", 32'(n), 32'h0);
    // R6: zero low length stays high
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd5, 16'd0});
    bus_write(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    count_high(0, 60, n);
    chk(n == 60, "R6 zero low stays high", 32'(n), 32'd60);

    // R7: both zero stays low
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, 32'h0);
    bus_write(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    count_high(0, 60, n);
    chk(n == 0, "R7 both zero stays low", 32'(n), 32'h0);

    // R8: disable in the middle of a long high phase
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd20, 16'd20});
    bus_write(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_rise(0);
    repeat (3) @(negedge clk);
    bus_write(4'h8, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0));
    chk(pwm_out[0] == 1'b1, "R8 one edge after write", 32'(pwm_out[0]), 32'h1);
    @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R8 low two edges after write", 32'(pwm_out[0]), 32'h0);

    // R9: a duty write during high waits for the next period
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd4, 16'd4});
    bus_write(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_rise(0);
    bus_write(4'h0, {16'd1, 16'd1});
    run_len(0, 1'b1, h);
    run_len(0, 1'b0, l);
    chk(h == 2, "R9 running high keeps old length", 32'(h), 32'd2);
    chk(l == 4, "R9 running low keeps old length", 32'(l), 32'd4);
    run_len(0, 1'b1, h);
    run_len(0, 1'b0, l);
    chk(h == 1, "R9 new high used next period", 32'(h), 32'd1);
    chk(l == 1, "R9 new low used next period", 32'(l), 32'd1);

    // R10: both channels at once with different settings
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd3, 16'd2});
    bus_write(4'h4, {16'd1, 16'd3});
    bus_write(4'h8, mk_ctrl(1, 1, 0, 1, 1, 1, 1, 0));
    measure(0, h, l);
    measure(0, h, l);
    chk(h == 6, "R10 ch0 high with ch1 running", 32'(h), 32'd6);
    chk(l == 4, "R10 ch0 low with ch1 running", 32'(l), 32'd4);
    measure(1, h, l);
    measure(1, h, l);
    chk(h == 2, "R10 ch1 high with ch0 running", 32'(h), 32'd2);
    chk(l == 6, "R10 ch1 low with ch0 running", 32'(l), 32'd6);
    // R10 R8: stopping ch0 leaves ch1 toggling
    bus_write(4'h8, mk_ctrl(0, 1, 0, 1, 1, 1, 1, 0));
    measure(1, h, l);
    chk(h == 2 && l == 6, "R10 ch1 unchanged after ch0 stop", 32'(h * 256 + l), 32'(2 * 256 + 6));
    chk(pwm_out[0] == 1'b0, "R10 ch0 stopped", 32'(pwm_out[0]), 32'h0);
    bus_read(4'h4, {16'd1, 16'd3}, "R11 read while running");

    compare_on = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule